// File: doc/BRIEF.md
# CPU-to-I/O Window Address Translator

This block sits on the CPU side of a bus bridge. The CPU reaches downstream I/O space through an 8 MB memory window at 0x8000_0000. Each request that lands in the window has its offset turned into a 20-bit I/O-bus address. The block then runs one downstream cycle with byte enables, waits for the acknowledge, and returns a response to the requester.

A level-sensitive mode input chooses between two address mappings:

- **Flat mapping.** The low 16 bits of the offset form a 64 KB contiguous I/O space.
- **Sparse mapping.** Offset bits 4:0 are kept. Every 4 KB page of the window then selects a 32-port group.

The mode input is synchronized. Its value is captured when a request is accepted, so changing the mode never disturbs a cycle already under way. Accesses may be 1, 2 or 4 bytes wide and need not be aligned. Bytes occupy lanes in little-endian order, starting at the lane given by the low two address bits and wrapping around the 4-byte bus. A request outside the window, or one with an illegal size, gets an error response and no downstream cycle.

Top module: `iowin_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `io_valid` and `rsp_valid` are both 0.
- R2: With the synchronized mode at 0, `io_addr` equals the window offset (`req_addr` minus 0x8000_0000) modulo 65536.
- R3: With the synchronized mode at 1, `io_addr` equals (offset mod 32) + 32 × floor(offset / 4096). Offset bits 11:5 do not take part.
- R4: A request with `req_addr` below 0x8000_0000 or at or above 0x8080_0000 is answered one cycle after acceptance with `rsp_valid`=1 and `rsp_err`=1, and `io_valid` never rises for it.
- R5: A request whose `req_size` (a byte count) is not 1, 2 or 4 is answered like R4: an error response and no downstream cycle.
- R6: Bit k of `io_be` enables lane k, which is `io_wdata`/`io_rdata` bits 8k+7:8k. Let L be `io_addr[1:0]` and N be `req_size`. The enabled lanes are exactly (L+i) mod 4 for i = 0 to N−1.
- R7: Byte i of `req_wdata` (bits 8i+7:8i) is driven on lane (L+i) mod 4 for i < N. Lanes that are not enabled carry zero. For a read, `io_wdata` is all zero.
- R8: `rsp_valid` rises one cycle after the cycle in which `io_valid` and `io_ack` are both 1. For a read, byte i of `rsp_rdata` equals lane (L+i) mod 4 of `io_rdata` for i < N and zero above that. For a write, `rsp_rdata` is zero and `rsp_err` is 0.
- R9: While `io_valid` waits for `io_ack`, `io_addr`, `io_be`, `io_wdata` and `io_write` hold steady and `req_ready` stays 0.
- R10: The mode applies to requests accepted at least 3 cycles after `mode_sel` changes. A change made while a downstream cycle is pending leaves that cycle's address unchanged.
- R11: A legal request, aligned or not, produces exactly one downstream cycle, starting the cycle after acceptance. This is followed by a single-cycle response and a return to `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Asynchronous mapping select: 0 flat, 1 sparse |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data, byte 0 in bits 7:0 |
| io_valid | output | 1 | Downstream cycle pending |
| io_ack | input | 1 | Downstream acknowledge |
| io_addr | output | 20 | I/O-space address |
| io_write | output | 1 | Downstream write |
| io_be | output | 4 | Lane enables |
| io_wdata | output | 32 | Lane-ordered write data |
| io_rdata | input | 32 | Lane-ordered read data |

## Verification
The bench builds the block with its defaults: an 8 MB window at 0x8000_0000, a 4-lane bus and a 2-flop mode synchronizer. With these values, every lane rotation and every size can be swept in both directions and both mappings, including the wrap past lane 3 and offsets at page boundaries and at the window's last byte. The small window also makes both edges just outside it cheap to hit, along with every illegal size code. A stalled acknowledge combined with a mid-cycle mode flip exercises the capture-at-accept rule.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int unsigned SZW = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } xfer_st_e;

    function automatic logic size_legal(input logic [SZW-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/iowin_mode_sync.sv
module iowin_mode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/iowin_addr_map.sv
module iowin_addr_map #(
    parameter int WIN_LOG2  = 23,
    parameter int IO_AW     = 20,
    parameter int PAGE_LOG2 = 12,
    parameter int KEEP_LO   = 5,
    parameter int FLAT_BITS = 16
) (
    input  logic [WIN_LOG2-1:0] offset,
    input  logic                sparse,
    output logic [IO_AW-1:0]    io_addr
);
    localparam int SPARSE_W = WIN_LOG2 - PAGE_LOG2 + KEEP_LO;

    logic [SPARSE_W-1:0]  sparse_addr;
    logic [FLAT_BITS-1:0] flat_addr;

    // page number lands directly above the kept low bits
    assign sparse_addr = {offset[WIN_LOG2-1:PAGE_LOG2], offset[KEEP_LO-1:0]};
    assign flat_addr   = offset[FLAT_BITS-1:0];

    always_comb begin
        if (sparse) io_addr = IO_AW'(sparse_addr);
        else        io_addr = IO_AW'(flat_addr);
    end
endmodule

// File: rtl/iowin_lane_pack.sv
module iowin_lane_pack #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lo,
    input  logic [2:0]               size,
    input  logic [8*LANES-1:0]       data_in,
    output logic [LANES-1:0]         be,
    output logic [8*LANES-1:0]       data_out
);
    localparam int LOG = $clog2(LANES);

    logic [LOG-1:0] lane_of [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_of[g] = lo + LOG'(g);
        end
    endgenerate

    always_comb begin
        be       = '0;
        data_out = '0;
        for (int i = 0; i < LANES; i++) begin
            if (int'(size) > i) begin
                be[lane_of[i]]               = 1'b1;
                data_out[lane_of[i]*8 +: 8]  = data_in[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/iowin_lane_unpack.sv
module iowin_lane_unpack #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lo,
    input  logic [2:0]               size,
    input  logic [8*LANES-1:0]       lane_data,
    output logic [8*LANES-1:0]       data_out
);
    localparam int LOG = $clog2(LANES);

    logic [LOG-1:0] lane_of [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_of[g] = lo + LOG'(g);
        end
    endgenerate

    always_comb begin
        data_out = '0;
        for (int i = 0; i < LANES; i++) begin
            if (int'(size) > i) data_out[i*8 +: 8] = lane_data[lane_of[i]*8 +: 8];
        end
    end
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
    import iowin_pkg::*;
#(
    parameter logic [31:0] WIN_BASE    = 32'h8000_0000,
    parameter int          WIN_LOG2    = 23,
    parameter int          IO_AW       = 20,
    parameter int          LANES       = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_sel,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [31:0]         req_addr,
    input  logic                req_write,
    input  logic [2:0]          req_size,
    input  logic [8*LANES-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [8*LANES-1:0]  rsp_rdata,
    output logic                io_valid,
    input  logic                io_ack,
    output logic [IO_AW-1:0]    io_addr,
    output logic                io_write,
    output logic [LANES-1:0]    io_be,
    output logic [8*LANES-1:0]  io_wdata,
    input  logic [8*LANES-1:0]  io_rdata
);
    localparam int DW  = 8 * LANES;
    localparam int LOG = $clog2(LANES);

    typedef struct packed {
        xfer_st_e        st;
        logic [IO_AW-1:0] addr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
        logic             write;
        logic [LOG-1:0]   lo;
        logic [SZW-1:0]   size;
        logic [DW-1:0]    rdata;
        logic             err;
    } xfer_t;

    xfer_t r_d, r_q;

    // mode synchronizer
    logic mode_sync;
    iowin_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mode_sel),
        .sync_out (mode_sync)
    );

    // window decode
    logic [31:0] offset_full;
    logic        in_window;
    logic        size_ok;
    assign offset_full = req_addr - WIN_BASE;
    assign in_window   = (offset_full >> WIN_LOG2) == 32'd0;
    assign size_ok     = size_legal(req_size);

    // offset to I/O address
    logic [IO_AW-1:0] mapped_addr;
    iowin_addr_map #(.WIN_LOG2(WIN_LOG2), .IO_AW(IO_AW)) u_map (
        .offset  (offset_full[WIN_LOG2-1:0]),
        .sparse  (mode_sync),
        .io_addr (mapped_addr)
    );

    // request lanes
    logic [LANES-1:0] pack_be;
    logic [DW-1:0]    pack_wdata;
    iowin_lane_pack #(.LANES(LANES)) u_pack (
        .lo       (mapped_addr[LOG-1:0]),
        .size     (req_size),
        .data_in  (req_wdata),
        .be       (pack_be),
        .data_out (pack_wdata)
    );

    // return lanes
    logic [DW-1:0] unpack_rdata;
    iowin_lane_unpack #(.LANES(LANES)) u_unpack (
        .lo        (r_q.lo),
        .size      (r_q.size),
        .lane_data (io_rdata),
        .data_out  (unpack_rdata)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.rdata = '0;
                    if (in_window && size_ok) begin
                        r_d.st    = ST_BUSY;
                        r_d.err   = 1'b0;
                        r_d.addr  = mapped_addr;
                        r_d.be    = pack_be;
                        r_d.wdata = req_write ? pack_wdata : '0;
                        r_d.write = req_write;
                        r_d.lo    = mapped_addr[LOG-1:0];
                        r_d.size  = req_size;
                    end else begin
                        r_d.st  = ST_RESP;
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (io_ack) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.write ? '0 : unpack_rdata;
                end
            end
            ST_RESP: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign io_valid  = (r_q.st == ST_BUSY);
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;
    assign io_addr   = r_q.addr;
    assign io_be     = r_q.be;
    assign io_wdata  = r_q.wdata;
    assign io_write  = r_q.write;
endmodule

// File: rtl/iowin_xlate_chk.sv
module iowin_xlate_chk #(
    parameter logic [31:0] WIN_BASE = 32'h8000_0000,
    parameter int          WIN_LOG2 = 23,
    parameter int          IO_AW    = 20,
    parameter int          LANES    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [31:0]        req_addr,
    input logic [2:0]         req_size,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic               io_valid,
    input logic               io_ack,
    input logic [IO_AW-1:0]   io_addr,
    input logic               io_write,
    input logic [LANES-1:0]   io_be,
    input logic [8*LANES-1:0] io_wdata
);
    logic [31:0] chk_off;
    logic        chk_hit;
    logic        chk_sz;
    assign chk_off = req_addr - WIN_BASE;
    assign chk_hit = chk_off < (32'd1 << WIN_LOG2);
    assign chk_sz  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

    assert_window_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !chk_hit |=> rsp_valid && rsp_err && !io_valid);

    assert_size_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !chk_sz |=> rsp_valid && rsp_err && !io_valid);

    assert_be_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> ($countones(io_be) == 1 || $countones(io_be) == 2 || $countones(io_be) == 4));

    assert_rsp_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && io_ack |=> rsp_valid && !rsp_err && !io_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ack |=> io_valid && $stable(io_addr) && $stable(io_be)
                                && $stable(io_wdata) && $stable(io_write));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid || rsp_valid) |-> !req_ready);

    assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && chk_hit && chk_sz |=> io_valid && !rsp_valid);

    assert_single_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);
endmodule

bind iowin_xlate iowin_xlate_chk #(
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2),
    .IO_AW    (IO_AW),
    .LANES    (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .io_valid  (io_valid),
    .io_ack    (io_ack),
    .io_addr   (io_addr),
    .io_write  (io_write),
    .io_be     (io_be),
    .io_wdata  (io_wdata)
);

// File: tb/iowin_xlate_tb.sv
`timescale 1ns/1ps
module iowin_xlate_tb;
    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam logic [31:0] WIN  = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        io_valid;
    logic        io_ack = 1'b0;
    logic [19:0] io_addr;
    logic        io_write;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic [31:0] io_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iowin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .io_valid(io_valid), .io_ack(io_ack), .io_addr(io_addr),
        .io_write(io_write), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_map(input logic [31:0] off, input bit sparse);
        if (sparse) return (off % 32) + (off / 4096) * 32;
        return off % 65536;
    endfunction

    function automatic logic [31:0] exp_be(input int lo, input int n);
        logic [31:0] b = '0;
        for (int i = 0; i < n; i++) b[(lo + i) % 4] = 1'b1;
        return b;
    endfunction

    function automatic logic [31:0] exp_wd(input int lo, input int n, input logic [31:0] d);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) w[((lo + i) % 4)*8 +: 8] = d[i*8 +: 8];
        return w;
    endfunction

    function automatic logic [31:0] exp_rd(input int lo, input int n, input logic [31:0] d);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = d[((lo + i) % 4)*8 +: 8];
        return r;
    endfunction

    task automatic settle_mode(input bit m);
        @(negedge clk);
        mode_sel = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic access(input logic [31:0] addr, input bit wr, input logic [2:0] sz,
                          input logic [31:0] wd, input bit mode, input int ack_wait,
                          input bit flip_mid);
        logic [31:0] off = addr - BASE;
        bit bad_win = (addr < BASE) || (addr >= BASE + WIN);
        bit bad_sz  = !(sz == 3'd1 || sz == 3'd2 || sz == 3'd4);
        logic [31:0] ea;
        logic [31:0] lanes;
        int lo;
        int n = int'(sz);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad_win || bad_sz) begin
            check(bad_win ? "R4 err valid" : "R5 err valid", {31'd0, rsp_valid}, 32'd1);
            check(bad_win ? "R4 err flag"  : "R5 err flag",  {31'd0, rsp_err},   32'd1);
            check(bad_win ? "R4 no io"     : "R5 no io",     {31'd0, io_valid},  32'd0);
            @(negedge clk);
            check("R11 idle after err", {31'd0, req_ready}, 32'd1);
            check(bad_win ? "R4 no io later" : "R5 no io later", {31'd0, io_valid}, 32'd0);
            return;
        end
        ea = exp_map(off, mode);
        lo = int'(ea[1:0]);
        check("R11 io cycle started", {31'd0, io_valid}, 32'd1);
        check(mode ? "R3 sparse addr" : "R2 flat addr", {12'd0, io_addr}, ea);
        check("R6 byte enables", {28'd0, io_be}, exp_be(lo, n));
        check("R7 write lanes", io_wdata, wr ? exp_wd(lo, n, wd) : 32'd0);
        check("R11 io_write", {31'd0, io_write}, {31'd0, wr});
        for (int k = 0; k < ack_wait; k++) begin
            if (flip_mid && k == 0) mode_sel = ~mode_sel;
            @(negedge clk);
            check("R9 held valid", {31'd0, io_valid}, 32'd1);
            check("R9 not ready", {31'd0, req_ready}, 32'd0);
            check(flip_mid ? "R10 addr kept" : "R9 addr held", {12'd0, io_addr}, ea);
        end
        lanes = {~addr[15:0], addr[15:0]} ^ 32'h5A3C_96E1;
        io_ack = 1'b1; io_rdata = lanes;
        @(negedge clk);
        io_ack = 1'b0; io_rdata = 32'hDEAD_BEEF;
        check("R8 rsp valid", {31'd0, rsp_valid}, 32'd1);
        check("R8 rsp ok", {31'd0, rsp_err}, 32'd0);
        check("R11 single io", {31'd0, io_valid}, 32'd0);
        check("R8 read data", rsp_rdata, wr ? 32'd0 : exp_rd(lo, n, lanes));
        @(negedge clk);
        check("R11 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
        check("R11 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    logic [31:0] offs [8] = '{32'h0, 32'h1C, 32'h3C, 32'hFFC, 32'h1000,
                              32'hABCDC, 32'h12344, 32'h7FFFFC};
    logic [2:0]  sizes [3] = '{3'd1, 3'd2, 3'd4};
    logic [2:0]  bad_sizes [5] = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        check("R1 no io in reset", {31'd0, io_valid}, 32'd0);
        check("R1 no rsp in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, req_ready, io_valid | rsp_valid}, 32'd2);

        for (int m = 0; m < 2; m++) begin
            settle_mode(m[0]);
            for (int j = 0; j < 8; j++)
                for (int lo = 0; lo < 4; lo++)
                    for (int s = 0; s < 3; s++)
                        for (int w = 0; w < 2; w++)
                            access(BASE + ((offs[j] & ~32'd3) | lo), w[0], sizes[s],
                                   32'h1122_3344 + 32'h0101_0101 * j, m[0], (j + s) % 3, 1'b0);
        end

        // R4: window edges
        access(BASE - 1, 1'b0, 3'd1, '0, 1'b1, 0, 1'b0);
        access(BASE + WIN, 1'b1, 3'd4, 32'h1, 1'b1, 0, 1'b0);
        access(32'h0, 1'b0, 3'd2, '0, 1'b1, 0, 1'b0);
        access(32'hFFFF_FFFF, 1'b0, 3'd1, '0, 1'b1, 0, 1'b0);
        access(BASE + WIN - 1, 1'b0, 3'd1, '0, 1'b1, 0, 1'b0);
        // R5: every illegal size
        for (int b = 0; b < 5; b++) access(BASE + 32'h40, b[0], bad_sizes[b], 32'hFF, 1'b1, 0, 1'b0);

        // R10: flip mode during a stalled cycle, then confirm new mode applies
        settle_mode(1'b0);
        access(BASE + 32'h12345, 1'b0, 3'd2, '0, 1'b0, 3, 1'b1);
        repeat (4) @(negedge clk);
        access(BASE + 32'h12345, 1'b0, 3'd2, '0, 1'b1, 0, 1'b0);
        settle_mode(1'b0);
        access(BASE + 32'h12345, 1'b1, 3'd4, 32'hCAFE_F00D, 1'b0, 0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11 actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule